// File: doc/BRIEF.md
# Single-Channel DMA Engine

This block moves a block of words between one peripheral data port and system memory without processor involvement beyond setup. Software writes a starting word address and a word count, then writes the control word with the GO bit set, choosing direction, bus mode and interrupt enable in the same write. The engine asks for the system bus, performs one read from the source side and one write to the destination side per word, steps the address up and the count down, and finally raises a done flag and, if enabled, an interrupt.

Two bus-ownership policies are offered. In cycle-steal mode the engine gives the bus back after every word and asks again for the next one. In burst mode it keeps the request up for the whole block. Bus cycles are only driven while the grant input is high.

The sequencer is a state machine with states IDLE, REQ, READ, WRITE, YIELD and FINISH. Transitions: IDLE to REQ on a start with nonzero count; IDLE to FINISH on a start with zero count; REQ to READ when granted; READ to WRITE when the source acknowledges; WRITE to FINISH when the last word is acknowledged, to READ for further words in burst mode, or to YIELD in cycle-steal mode; YIELD to REQ after one cycle with the request low; FINISH to IDLE after one cycle.

Top module: `dma_channel`

## Requirements
- R1: After reset the address, count and control/status registers read 0, and bus_req, irq and all four strobes are 0.
- R2: A write of the control register (cfg_sel=2) with bit 0 (GO) set and a nonzero count raises bus_req, and the status bit 6 (busy) reads 1 until the block ends.
- R3: Control bit 1 picks the direction: 1 moves memory to device, 0 moves device to memory; each word is read from the source side and then written unchanged to the destination side.
- R4: No memory or device strobe is asserted in a cycle where bus_gnt is low.
- R5: Each completed word raises the address register (cfg_sel=0) by one and lowers the count register (cfg_sel=1) by one; after N words the address is start+N and the count is 0.
- R6: With control bit 3 clear (cycle steal), bus_req drops for at least one cycle after every word, so a block of N words shows N rising edges of bus_req.
- R7: With control bit 3 set (burst), bus_req stays high from the first request until the last word, showing one rising edge per block.
- R8: Status bit 4 (done) becomes 1 when the block completes and is cleared by the next accepted GO write.
- R9: With control bit 2 (interrupt enable) set, completion sets status bit 5 (IRQ) and the irq output; with it clear, neither is set.
- R10: A read or write of the control register while IRQ is set clears status bit 5 and drops irq on the next cycle.
- R11: A GO write with a count of 0 sets done without ever raising bus_req.
- R12: While busy, writes to the address, count and control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (used to clear IRQ) |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, combinational |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe, held until mem_ack |
| mem_wr | output | 1 | Memory write strobe, held until mem_ack |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| dev_rd | output | 1 | Device read strobe, held until dev_ack |
| dev_wr | output | 1 | Device write strobe, held until dev_ack |
| dev_wdata | output | DATA_W | Device write data |
| dev_rdata | input | DATA_W | Device read data, valid with dev_ack |
| dev_ack | input | 1 | Device acknowledge |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest situation to reach from the ports is a transfer that is started but stalled mid-flight, since a normally granted block finishes in a few cycles and leaves no window to probe the busy-time write lock or the no-grant rule. The bench's bus arbiter model has a grant enable that it holds low, so a started block sits in REQ with bus_req high; during that window the bench reads busy and done, tries to overwrite address and count, and watches that no strobe appears, then releases the grant and checks the block still completes from the original settings.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_READ,
        ST_WRITE,
        ST_YIELD,
        ST_FINISH
    } dma_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int BIT_GO    = 0;
    localparam int BIT_DIR   = 1;
    localparam int BIT_IE    = 2;
    localparam int BIT_BURST = 3;
    localparam int BIT_DONE  = 4;
    localparam int BIT_IRQ   = 5;
    localparam int BIT_BUSY  = 6;

endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_sel,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              blk_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cnt_zero,
    output logic              cnt_last,
    output logic              dir_m2d,
    output logic              burst,
    output logic              start,
    output logic              irq
);
    import dma_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dir_q, ie_q, burst_q, done_q, irq_q;
    logic              ctrl_hit, cfg_open;

    assign ctrl_hit = (cfg_sel == SEL_CTRL) && (cfg_wr || cfg_rd);
    assign cfg_open = cfg_wr && !busy;
    assign start    = cfg_open && (cfg_sel == SEL_CTRL) && cfg_wdata[BIT_GO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            ie_q    <= 1'b0;
            burst_q <= 1'b0;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (step) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - CNT_ONE;
            end else if (cfg_open && cfg_sel == SEL_ADDR) begin
                addr_q <= cfg_wdata[ADDR_W-1:0];
            end else if (cfg_open && cfg_sel == SEL_CNT) begin
                cnt_q <= cfg_wdata[CNT_W-1:0];
            end
            if (cfg_open && cfg_sel == SEL_CTRL) begin
                dir_q   <= cfg_wdata[BIT_DIR];
                ie_q    <= cfg_wdata[BIT_IE];
                burst_q <= cfg_wdata[BIT_BURST];
            end
            if (start)
                done_q <= 1'b0;
            else if (blk_done)
                done_q <= 1'b1;
            if (blk_done && ie_q)
                irq_q <= 1'b1;
            else if (ctrl_hit)
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_sel)
            SEL_ADDR: cfg_rdata = DATA_W'(addr_q);
            SEL_CNT:  cfg_rdata = DATA_W'(cnt_q);
            SEL_CTRL: begin
                cfg_rdata[BIT_DIR]   = dir_q;
                cfg_rdata[BIT_IE]    = ie_q;
                cfg_rdata[BIT_BURST] = burst_q;
                cfg_rdata[BIT_DONE]  = done_q;
                cfg_rdata[BIT_IRQ]   = irq_q;
                cfg_rdata[BIT_BUSY]  = busy;
            end
            default: cfg_rdata = '0;
        endcase
    end

    assign cur_addr = addr_q;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_ONE);
    assign dir_m2d  = dir_q;
    assign burst    = burst_q;
    assign irq      = irq_q;

    // R5: every completed word moves address and count by one
    a_r5_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == $past(cnt_q) - CNT_ONE) && (addr_q == $past(addr_q) + 1'b1));

    // R12: programmed values hold while busy apart from stepping
    a_r12_locked_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> $stable(addr_q) && $stable(cnt_q));

    // R10: a control access clears a pending interrupt
    a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && irq_q && !blk_done) |=> !irq_q);

    // R9: interrupt only rises from an enabled completion
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(blk_done && ie_q));

endmodule

// File: rtl/dma_route.sv
module dma_route #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_m2d,
    input  logic              src_rd,
    input  logic              dst_wr,
    output logic              src_ack,
    output logic              dst_ack,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ack
);
    logic [DATA_W-1:0] hold_q;

    assign mem_rd  = src_rd &&  dir_m2d;
    assign dev_rd  = src_rd && !dir_m2d;
    assign dev_wr  = dst_wr &&  dir_m2d;
    assign mem_wr  = dst_wr && !dir_m2d;
    assign src_ack = dir_m2d ? mem_ack : dev_ack;
    assign dst_ack = dir_m2d ? dev_ack : mem_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (src_rd && src_ack)
            hold_q <= dir_m2d ? mem_rdata : dev_rdata;
    end

    assign mem_wdata = hold_q;
    assign dev_wdata = hold_q;

    // R3: at most one side is strobed at any time
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, dev_rd, dev_wr}));

endmodule

// File: rtl/dma_seq.sv
module dma_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic burst,
    input  logic bus_gnt,
    input  logic src_ack,
    input  logic dst_ack,
    output logic bus_req,
    output logic src_rd,
    output logic dst_wr,
    output logic step,
    output logic blk_done,
    output logic busy
);
    import dma_pkg::*;

    dma_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = cnt_zero ? ST_FINISH : ST_REQ;
            ST_REQ:    if (bus_gnt) state_d = ST_READ;
            ST_READ:   if (bus_gnt && src_ack) state_d = ST_WRITE;
            ST_WRITE:  if (bus_gnt && dst_ack) begin
                           if (cnt_last)   state_d = ST_FINISH;
                           else if (burst) state_d = ST_READ;
                           else            state_d = ST_YIELD;
                       end
            ST_YIELD:  state_d = ST_REQ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = 1'b0;
        src_rd   = 1'b0;
        dst_wr   = 1'b0;
        step     = 1'b0;
        blk_done = 1'b0;
        busy     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   ;
            ST_REQ:    bus_req = 1'b1;
            ST_READ: begin
                bus_req = 1'b1;
                src_rd  = bus_gnt;
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                dst_wr  = bus_gnt;
                step    = bus_gnt && dst_ack;
            end
            ST_YIELD:  ;
            ST_FINISH: blk_done = 1'b1;
            default:   ;
        endcase
    end

    // R4: strobes only under grant
    a_r4_grant_only: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd || dst_wr) |-> bus_gnt);

    // R6: cycle steal gives the bus back after a word
    a_r6_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !burst && !cnt_last) |=> !bus_req);

    // R7: burst keeps the bus between words
    a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && burst && !cnt_last) |=> bus_req);

    // R11: an empty block never asks for the bus
    a_r11_zero_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt_zero && !busy) |=> !bus_req && blk_done);

    // R8: the last word leads straight to completion
    a_r8_last_done: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_last) |=> blk_done);

endmodule

// File: rtl/dma_channel.sv
module dma_channel #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_sel,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ack,
    output logic              irq
);
    logic busy, step, blk_done, cnt_zero, cnt_last, dir_m2d, burst, start;
    logic src_rd, dst_wr, src_ack, dst_ack;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .step(step), .blk_done(blk_done),
        .cur_addr(mem_addr), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .dir_m2d(dir_m2d), .burst(burst), .start(start), .irq(irq)
    );

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .burst(burst), .bus_gnt(bus_gnt),
        .src_ack(src_ack), .dst_ack(dst_ack),
        .bus_req(bus_req), .src_rd(src_rd), .dst_wr(dst_wr),
        .step(step), .blk_done(blk_done), .busy(busy)
    );

    dma_route #(.DATA_W(DATA_W)) u_route (
        .clk(clk), .rst_n(rst_n),
        .dir_m2d(dir_m2d), .src_rd(src_rd), .dst_wr(dst_wr),
        .src_ack(src_ack), .dst_ack(dst_ack),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_ack(dev_ack)
    );

endmodule

// File: tb/tb_dma_channel.sv
`timescale 1ns/1ps
module tb_dma_channel;
    localparam int AW = 16, CW = 16, DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic bus_req, mem_rd, mem_wr, dev_rd, dev_wr, irq;
    logic bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, dev_wdata, mem_rdata, dev_rdata;
    logic mem_ack = 1'b0, dev_ack = 1'b0;

    logic gnt_en = 1'b1;
    logic model_clr = 1'b1;
    logic req_prev = 1'b0;
    logic [DW-1:0] mem [64];
    logic [DW-1:0] dev_log [64];
    int dev_rd_n = 0, dev_wr_n = 0, rises = 0, nogrant_n = 0;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    dma_channel #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[5:0]];
    assign dev_rdata = 32'hD000_0000 + 32'(dev_rd_n);

    // memory, device and arbiter models
    always @(posedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 + 32'(i);
            dev_rd_n <= 0;
            dev_wr_n <= 0;
            rises    <= 0;
            mem_ack  <= 1'b0;
            dev_ack  <= 1'b0;
        end else begin
            mem_ack <= (mem_rd || mem_wr) && !mem_ack;
            dev_ack <= (dev_rd || dev_wr) && !dev_ack;
            if (mem_wr && mem_ack) mem[mem_addr[5:0]] <= mem_wdata;
            if (dev_rd && dev_ack) dev_rd_n <= dev_rd_n + 1;
            if (dev_wr && dev_ack) begin
                dev_log[dev_wr_n[5:0]] <= dev_wdata;
                dev_wr_n <= dev_wr_n + 1;
            end
            if (bus_req && !req_prev) rises <= rises + 1;
        end
        req_prev <= bus_req;
        bus_gnt  <= bus_req && gnt_en;
        if ((mem_rd || mem_wr || dev_rd || dev_wr) && !bus_gnt) nogrant_n <= nogrant_n + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [DW-1:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic clear_models();
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
    endtask

    task automatic wait_done();
        logic [DW-1:0] c;
        for (int k = 0; k < 2000; k++) begin
            rd_reg(2'd1, c);
            if (c == 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // vector: addr[26:19] cnt[18:11] dir[10] burst[9] ie[8] expected rises[7:0]
    localparam int NV = 6;
    localparam logic [26:0] VEC [NV] = '{
        {8'd4,  8'd3, 1'b1, 1'b0, 1'b1, 8'd3},
        {8'd10, 8'd5, 1'b0, 1'b1, 1'b0, 8'd1},
        {8'd20, 8'd1, 1'b1, 1'b1, 1'b1, 8'd1},
        {8'd30, 8'd4, 1'b0, 1'b0, 1'b1, 8'd4},
        {8'd40, 8'd6, 1'b1, 1'b1, 1'b0, 8'd1},
        {8'd50, 8'd2, 1'b0, 1'b0, 1'b0, 8'd2}
    };

    initial begin
        logic [DW-1:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_clr = 1'b0;

        // R1 reset state
        rd_reg(2'd0, r); check(r == 0, "R1 addr", r, 0);
        rd_reg(2'd1, r); check(r == 0, "R1 count", r, 0);
        rd_reg(2'd2, r); check(r == 0, "R1 status", r, 0);
        check(!bus_req && !irq && !mem_rd && !mem_wr && !dev_rd && !dev_wr, "R1 outputs",
              {bus_req, irq, mem_rd, mem_wr, dev_rd, dev_wr}, 0);

        // R11 zero count: done at once, no request, irq with IE
        clear_models();
        wr_reg(2'd1, 0);
        wr_reg(2'd2, 32'h5);
        repeat (3) @(negedge clk);
        check(rises == 0, "R11 no bus_req", rises, 0);
        check(irq == 1'b1, "R9 irq zero-count", irq, 1);
        rd_reg(2'd2, r);
        check(r[4] == 1'b1, "R11 done", r[4], 1);

        // R12/R8/R2/R4 stalled transfer
        clear_models();
        gnt_en = 1'b0;
        wr_reg(2'd0, 5);
        wr_reg(2'd1, 3);
        wr_reg(2'd2, 32'hF);
        repeat (2) @(negedge clk);
        rd_reg(2'd2, r);
        check(r[6] == 1'b1, "R2 busy", r[6], 1);
        check(r[4] == 1'b0, "R8 done cleared", r[4], 0);
        check(bus_req == 1'b1, "R2 bus_req", bus_req, 1);
        wr_reg(2'd0, 32'h3F);
        wr_reg(2'd1, 9);
        wr_reg(2'd2, 32'h1);
        repeat (20) @(negedge clk);
        rd_reg(2'd0, r); check(r == 5, "R12 addr locked", r, 5);
        rd_reg(2'd1, r); check(r == 3, "R12 count locked", r, 3);
        rd_reg(2'd2, r); check(r[3:1] == 3'b111, "R12 ctrl locked", r[3:1], 7);
        check(nogrant_n == 0 && dev_rd_n == 0 && dev_wr_n == 0, "R4 no cycle without grant",
              nogrant_n + dev_wr_n, 0);
        gnt_en = 1'b1;
        wait_done();
        rd_reg(2'd0, r); check(r == 8, "R5 final addr", r, 8);
        check(irq == 1'b1, "R9 irq set", irq, 1);
        // R10 clear by write of control with GO low
        wr_reg(2'd2, 32'h0);
        check(irq == 1'b0, "R10 irq cleared by write", irq, 0);
        rd_reg(2'd2, r);
        check(r[5] == 1'b0 && r[4] == 1'b1, "R10 status after write", r[5:4], 1);

        // table-driven transfers: R3 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            int a, n, bad;
            logic d, b, ie;
            a = int'(VEC[v][26:19]); n = int'(VEC[v][18:11]);
            d = VEC[v][10]; b = VEC[v][9]; ie = VEC[v][8];
            clear_models();
            wr_reg(2'd0, DW'(a));
            wr_reg(2'd1, DW'(n));
            wr_reg(2'd2, {28'd0, b, ie, d, 1'b1});
            wait_done();
            rd_reg(2'd0, r); check(r == DW'(a + n), "R5 addr advance", r, a + n);
            rd_reg(2'd1, r); check(r == 0, "R5 count empty", r, 0);
            check(rises == int'(VEC[v][7:0]), b ? "R7 burst one request" : "R6 steal per word",
                  rises, VEC[v][7:0]);
            check(irq == ie, "R9 irq vs enable", irq, ie);
            rd_reg(2'd2, r);
            check(r[4] == 1'b1, "R8 done set", r[4], 1);
            check(r[5] == ie, "R9 IRQ bit", r[5], ie);
            check(irq == 1'b0, "R10 irq cleared by read", irq, 0);
            bad = 0;
            for (int i = 0; i < n; i++) begin
                if (d && dev_log[i] != 32'hA500_0000 + 32'(a + i)) bad++;
                if (!d && mem[a + i] != 32'hD000_0000 + 32'(i)) bad++;
            end
            check(bad == 0, "R3 data moved", bad, 0);
            check(nogrant_n == 0, "R4 grant rule", nogrant_n, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule